// File: doc/BRIEF.md
# Main Oscillator Failure Monitor

This block watches the frequency of an external main oscillator by using an internal reference oscillator that never stops. In each fixed window of `WINDOW` reference cycles it counts the rising edges of the main clock. It then checks the count against a low limit and a high limit that software programs. A count below the low limit, a count above the high limit, or a handshake that never comes back because the main clock has stopped is treated as a failure.

On a failure the block does three things. It sets a sticky fail flag. It latches a clock-select override that tells the system clock multiplexer to run from the internal oscillator. It then takes one of two responses, chosen by an action bit. The first response is a reset request pulse of fixed length, followed by a pending non-maskable interrupt once the pulse ends. The second response is an ordinary interrupt. The fail flag, the override and the pending non-maskable interrupt are not cleared by the system reset, including the reset that the block requests itself. They are cleared by writing one to the clear input or by power-on reset.

Top module: `mosc_fail_monitor`

## Requirements
- R1: With `en` high and a main clock whose edge count per window lies within [`lim_lo`, `lim_hi`], including counts close to either limit, `fail_sts`, `clk_sel_int`, `irq` and `nmi` stay 0.
- R2: A main clock whose edge count per window is greater than `lim_hi` sets `fail_sts` within three windows.
- R3: A main clock whose edge count per window is less than `lim_lo` sets `fail_sts` within three windows.
- R4: A main clock that stops completely sets `fail_sts` within three windows after it stops.
- R5: While `en` is 0, no failure is reported, even when the main clock is stopped.
- R6: A failure sets `clk_sel_int` to 1. It stays 1 even after the main clock recovers, until `clr_fail` is high for one cycle. That cycle clears `clk_sel_int`, `fail_sts`, `irq` and `nmi` together.
- R7: With `act_int` = 0 (reset action), a failure drives `rst_req` high for exactly `RST_LEN` consecutive reference cycles. `nmi` is 1 in the first cycle after `rst_req` falls, and `irq` stays 0.
- R8: With `act_int` = 1 (interrupt action), a failure sets `irq` to 1, while `rst_req` and `nmi` stay 0.
- R9: Asserting `rst` leaves `fail_sts`, `clk_sel_int` and `nmi` unchanged. Asserting `por` clears every output to 0.
- R10: While `fail_sts` is already 1, further failures start no new `rst_req` pulse.
- R11: When a failure and `clr_fail` fall in the same cycle, the failure wins: `fail_sts` and the selected response are still set.
- R12: The first measurement after `en` rises is discarded, so a count left over from before enabling never raises a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference clock, always running |
| mosc_clk | input | 1 | Main oscillator clock being monitored |
| rst | input | 1 | System reset, synchronous, active high |
| por | input | 1 | Power-on reset; also clears the sticky state |
| en | input | 1 | Enables detection |
| act_int | input | 1 | Action select: 0 = reset then NMI, 1 = interrupt |
| lim_lo | input | CNT_W | Lowest allowed edge count per window |
| lim_hi | input | CNT_W | Highest allowed edge count per window |
| clr_fail | input | 1 | Write-one-to-clear of the fail status |
| fail_sts | output | 1 | Sticky oscillator-fail cause flag |
| clk_sel_int | output | 1 | Override that forces the system clock to the internal oscillator |
| rst_req | output | 1 | Reset request pulse, `RST_LEN` reference cycles long |
| irq | output | 1 | Interrupt request (interrupt action) |
| nmi | output | 1 | Pending non-maskable interrupt (reset action) |

## Verification
A failure event and a software clear of the fail status can land on the same reference edge, and the block must then keep the failure. To provoke this, the bench stops the main clock with interrupt action selected and holds `clr_fail` high across several windows, so that every stall detection collides with an active clear. The bench passes this case only if `fail_sts` and `irq` each read as 1 in at least one sampled cycle during the hold. With a clear-wins priority the clear would absorb every event and both signals would read 0 throughout.

// File: rtl/mosc_mon_pkg.sv
package mosc_mon_pkg;

    typedef enum logic {
        ACT_RESET = 1'b0,
        ACT_IRQ   = 1'b1
    } fail_act_e;

    typedef enum logic [1:0] {
        GRADE_OK   = 2'd0,
        GRADE_SLOW = 2'd1,
        GRADE_FAST = 2'd2
    } grade_e;

    // Classify one window's edge count against the limits
    function automatic grade_e grade_count(input logic [31:0] cnt,
                                           input logic [31:0] lo,
                                           input logic [31:0] hi);
        if (cnt < lo) return GRADE_SLOW;
        if (cnt > hi) return GRADE_FAST;
        return GRADE_OK;
    endfunction

endpackage

// File: rtl/mosc_edge_counter.sv
// Main-clock domain: counts edges and answers snapshot requests by toggling
module mosc_edge_counter #(
    parameter int CNT_W = 10
) (
    input  logic             mosc_clk,
    input  logic             rst,
    input  logic             req_t,
    output logic [CNT_W-1:0] snap,
    output logic             ack_t
);
    logic [1:0]       rst_sync;
    logic             rst_m;
    logic [2:0]       req_sync;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge mosc_clk) rst_sync <= {rst_sync[0], rst};
    assign rst_m = rst_sync[1];

    always_ff @(posedge mosc_clk) begin
        if (rst_m) begin
            req_sync <= '0;
            cnt      <= '0;
            snap     <= '0;
            ack_t    <= 1'b0;
        end else begin
            req_sync <= {req_sync[1:0], req_t};
            if (req_sync[2] != req_sync[1]) begin
                snap  <= cnt;
                cnt   <= CNT_W'(1);
                ack_t <= req_sync[1];
            end else if (cnt != '1) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/mosc_window_ctl.sv
// Reference domain: window timing, handshake and limit comparison
module mosc_window_ctl
    import mosc_mon_pkg::*;
#(
    parameter int WINDOW = 64,
    parameter int CNT_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [CNT_W-1:0] snap,
    input  logic             ack_t,
    output logic             req_t,
    output logic             fail_evt
);
    localparam int WIN_W = $clog2(WINDOW + 1);

    logic [WIN_W-1:0] tick;
    logic [2:0]       ack_sync;
    logic             primed;
    logic             win_end, ack_edge, pending;
    grade_e           verdict;

    assign win_end  = (tick == WIN_W'(WINDOW - 1));
    assign ack_edge = (ack_sync[2] != ack_sync[1]);
    assign pending  = (req_t != ack_sync[1]);
    assign verdict  = grade_count(32'(snap), 32'(lim_lo), 32'(lim_hi));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick     <= '0;
            ack_sync <= '0;
            primed   <= 1'b0;
            req_t    <= 1'b0;
            fail_evt <= 1'b0;
        end else begin
            ack_sync <= {ack_sync[1:0], ack_t};
            fail_evt <= 1'b0;
            if (!en) begin
                tick   <= '0;
                primed <= 1'b0;
            end else begin
                tick <= win_end ? '0 : tick + WIN_W'(1);
                if (ack_edge) begin
                    if (primed && verdict != GRADE_OK) fail_evt <= 1'b1;
                    primed <= 1'b1;
                end
                if (win_end) begin
                    if (pending) begin
                        fail_evt <= 1'b1;   // stalled main clock
                        primed   <= 1'b0;
                    end else begin
                        req_t <= ~req_t;
                    end
                end
            end
        end
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> !fail_evt) else $error("fail while disabled"); // R5
endmodule

// File: rtl/mosc_fail_resp.sv
// Sticky status, clock override, reset pulse, interrupt and NMI
module mosc_fail_resp
    import mosc_mon_pkg::*;
#(
    parameter int RST_LEN = 8
) (
    input  logic      clk,
    input  logic      por,
    input  logic      rst,
    input  logic      fail_evt,
    input  fail_act_e act,
    input  logic      clr_fail,
    output logic      fail_sts,
    output logic      clk_sel_int,
    output logic      rst_req,
    output logic      irq,
    output logic      nmi
);
    localparam int RL_W = $clog2(RST_LEN + 1);

    logic            take, pulse_end;
    logic [RL_W-1:0] pcnt;

    assign take      = fail_evt && !fail_sts;
    assign pulse_end = rst_req && (pcnt == RL_W'(RST_LEN - 1));

    // survives rst, set wins over clear
    always_ff @(posedge clk) begin
        if (por)           fail_sts <= 1'b0;
        else if (fail_evt) fail_sts <= 1'b1;
        else if (clr_fail) fail_sts <= 1'b0;
    end
    assign clk_sel_int = fail_sts;

    always_ff @(posedge clk) begin
        if (por) begin
            rst_req <= 1'b0;
            pcnt    <= '0;
        end else if (take && act == ACT_RESET) begin
            rst_req <= 1'b1;
            pcnt    <= '0;
        end else if (rst_req) begin
            if (pulse_end) rst_req <= 1'b0;
            pcnt <= pcnt + RL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (por)            nmi <= 1'b0;
        else if (pulse_end) nmi <= 1'b1;
        else if (clr_fail)  nmi <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (por || rst)                   irq <= 1'b0;
        else if (take && act == ACT_IRQ)  irq <= 1'b1;
        else if (clr_fail)                irq <= 1'b0;
    end

    AST_OVERRIDE_ON: assert property (@(posedge clk) disable iff (por)
        fail_evt |=> clk_sel_int) else $error("override not set"); // R6
    AST_REQ_NOT_IRQ: assert property (@(posedge clk) disable iff (por)
        rst_req |-> !irq) else $error("irq during reset pulse"); // R7
    AST_NMI_AFTER_PULSE: assert property (@(posedge clk) disable iff (por)
        $rose(nmi) |-> $past(rst_req)) else $error("nmi without pulse"); // R7
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (por)
        !(nmi && irq)) else $error("both responses"); // R8
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (por)
        $rose(rst_req) |-> $past(!fail_sts)) else $error("retriggered"); // R10
endmodule

// File: rtl/mosc_fail_monitor.sv
module mosc_fail_monitor
    import mosc_mon_pkg::*;
#(
    parameter int WINDOW  = 64,
    parameter int CNT_W   = 10,
    parameter int RST_LEN = 8
) (
    input  logic             ref_clk,
    input  logic             mosc_clk,
    input  logic             rst,
    input  logic             por,
    input  logic             en,
    input  logic             act_int,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic             clr_fail,
    output logic             fail_sts,
    output logic             clk_sel_int,
    output logic             rst_req,
    output logic             irq,
    output logic             nmi
);
    logic [CNT_W-1:0] snap;
    logic             req_t, ack_t, fail_evt;
    fail_act_e        act;

    assign act = fail_act_e'(act_int);

    mosc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .mosc_clk (mosc_clk),
        .rst      (rst),
        .req_t    (req_t),
        .snap     (snap),
        .ack_t    (ack_t)
    );

    mosc_window_ctl #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_win (
        .clk      (ref_clk),
        .rst      (rst),
        .en       (en),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi),
        .snap     (snap),
        .ack_t    (ack_t),
        .req_t    (req_t),
        .fail_evt (fail_evt)
    );

    mosc_fail_resp #(.RST_LEN(RST_LEN)) u_resp (
        .clk         (ref_clk),
        .por         (por),
        .rst         (rst),
        .fail_evt    (fail_evt),
        .act         (act),
        .clr_fail    (clr_fail),
        .fail_sts    (fail_sts),
        .clk_sel_int (clk_sel_int),
        .rst_req     (rst_req),
        .irq         (irq),
        .nmi         (nmi)
    );
endmodule

// File: tb/mosc_fail_monitor_test.sv
`timescale 1ns/1ps
module mosc_fail_monitor_test;
    localparam int WINDOW  = 64;
    localparam int CNT_W   = 10;
    localparam int RST_LEN = 8;

    typedef struct packed {
        logic [15:0]      half_ps;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic             bad;
    } vec_t;

    // 256 ns window: 5 ns period -> ~51 edges, 3 ns -> ~85, 8 ns -> ~32
    localparam vec_t VECS [7] = '{
        '{16'd2500, 10'd40, 10'd60, 1'b0},   // R1 nominal
        '{16'd1500, 10'd40, 10'd60, 1'b1},   // R2 fast
        '{16'd4000, 10'd40, 10'd60, 1'b1},   // R3 slow
        '{16'd2500, 10'd55, 10'd70, 1'b1},   // R3 below raised low limit
        '{16'd2500, 10'd30, 10'd45, 1'b1},   // R2 above lowered high limit
        '{16'd3000, 10'd40, 10'd60, 1'b0},   // R1 near low limit
        '{16'd2200, 10'd40, 10'd60, 1'b0}    // R1 near high limit
    };

    logic ref_clk = 0, mosc_clk = 0;
    logic rst = 1, por = 1, en = 0, act_int = 1, clr_fail = 0;
    logic [CNT_W-1:0] lim_lo = 10'd40, lim_hi = 10'd60;
    logic fail_sts, clk_sel_int, rst_req, irq, nmi;

    real  mhalf = 2.5;
    logic mosc_run = 1;
    int   total = 0, bad = 0, cycles = 0;

    mosc_fail_monitor #(.WINDOW(WINDOW), .CNT_W(CNT_W), .RST_LEN(RST_LEN)) uut (
        .ref_clk(ref_clk), .mosc_clk(mosc_clk), .rst(rst), .por(por), .en(en),
        .act_int(act_int), .lim_lo(lim_lo), .lim_hi(lim_hi), .clr_fail(clr_fail),
        .fail_sts(fail_sts), .clk_sel_int(clk_sel_int), .rst_req(rst_req),
        .irq(irq), .nmi(nmi)
    );

    always #2 ref_clk = ~ref_clk;

    always begin
        if (mosc_run) #(mhalf) mosc_clk = ~mosc_clk;
        else #1;
    end

    always @(posedge ref_clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic power_up();
        por = 1; rst = 1; en = 0; clr_fail = 0;
        tick(10);
        por = 0; rst = 0;
        tick(2);
    endtask

    initial begin
        int n;
        int seen_sts;
        int seen_irq;
        power_up();
        // R9 reset state after power-on
        check("R9 reset fail_sts", fail_sts, 0);
        check("R9 reset clk_sel_int", clk_sel_int, 0);
        check("R9 reset rst_req", rst_req, 0);
        check("R9 reset irq/nmi", {irq, nmi}, 0);

        // table of clock rates and limits, interrupt action
        for (int i = 0; i < 7; i++) begin
            mhalf = real'(VECS[i].half_ps) / 1000.0;
            mosc_run = 1;
            act_int = 1;
            lim_lo = VECS[i].lo;
            lim_hi = VECS[i].hi;
            power_up();
            en = 1;
            tick(8 * WINDOW);
            check($sformatf("R1/R2/R3 vec%0d fail_sts", i), fail_sts, int'(VECS[i].bad));
            check($sformatf("R6 vec%0d clk_sel_int", i), clk_sel_int, int'(VECS[i].bad));
            check($sformatf("R8 vec%0d irq", i), irq, int'(VECS[i].bad));
            en = 0;
        end
        lim_lo = 10'd40; lim_hi = 10'd60;

        // R12: long disabled period saturates the edge count, then enable
        mhalf = 2.5; power_up();
        tick(1500);
        en = 1;
        tick(8 * WINDOW);
        check("R12 stale count discarded", fail_sts, 0);

        // R5: disabled with a stopped clock
        power_up();
        mosc_run = 0;
        tick(6 * WINDOW);
        check("R5 disabled no fail", fail_sts, 0);
        check("R5 disabled no irq", irq, 0);
        mosc_run = 1;

        // R4: clock stops after running correctly
        power_up(); act_int = 1; en = 1;
        tick(4 * WINDOW);
        check("R4 before stop", fail_sts, 0);
        mosc_run = 0;
        tick(3 * WINDOW + 20);
        check("R4 stopped fail_sts", fail_sts, 1);
        check("R4 stopped irq", irq, 1);
        mosc_run = 1;

        // R11: clear held high while stall failures keep arriving
        power_up(); act_int = 1; en = 1;
        tick(3 * WINDOW);
        clr_fail = 1; mosc_run = 0;
        seen_sts = 0; seen_irq = 0;
        for (int c = 0; c < 6 * WINDOW; c++) begin
            tick(1);
            if (fail_sts) seen_sts++;
            if (irq) seen_irq++;
        end
        clr_fail = 0; mosc_run = 1;
        check("R11 set wins fail_sts", int'(seen_sts > 0), 1);
        check("R11 set wins irq", int'(seen_irq > 0), 1);

        // R6: override latched until cleared
        mhalf = 1.5; power_up(); act_int = 1; en = 1;
        tick(6 * WINDOW);
        check("R6 fail set", fail_sts, 1);
        mhalf = 2.5;
        tick(6 * WINDOW);
        check("R6 override held after recovery", clk_sel_int, 1);
        clr_fail = 1; tick(1); clr_fail = 0; tick(1);
        check("R6 cleared fail_sts", fail_sts, 0);
        check("R6 cleared clk_sel_int", clk_sel_int, 0);
        check("R6 cleared irq", irq, 0);
        tick(6 * WINDOW);
        check("R6 stays clear", clk_sel_int, 0);

        // R7: reset action pulse then NMI
        mhalf = 1.5; power_up(); act_int = 0; en = 1;
        n = 0;
        while (!rst_req && n < 1000) begin tick(1); n++; end
        check("R7 pulse started", rst_req, 1);
        n = 0;
        while (rst_req && n < 100) begin n++; tick(1); end
        check("R7 pulse length", n, RST_LEN);
        check("R7 nmi after pulse", nmi, 1);
        check("R7 no irq", irq, 0);
        // R10: failures keep coming, no second pulse
        n = 0;
        for (int c = 0; c < 5 * WINDOW; c++) begin
            tick(1);
            if (rst_req) n++;
        end
        check("R10 no retrigger", n, 0);
        // R9: system reset keeps the sticky state
        rst = 1; tick(5); rst = 0; tick(2);
        check("R9 fail_sts survives rst", fail_sts, 1);
        check("R9 clk_sel_int survives rst", clk_sel_int, 1);
        check("R9 nmi survives rst", nmi, 1);
        power_up();
        check("R9 por clears", {fail_sts, clk_sel_int, rst_req, irq, nmi}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule